// File: doc/BRIEF.md
# Open-Row SDRAM Burst Read Sequencer

This block turns host read requests into SDRAM command sequences for four-beat burst reads. It leaves rows open after each access and keeps, for every bank, the row that is currently open and whether the bank holds one. Each new request is sorted into one of three cases. A request to the open row issues a READ at once. A request to an idle bank issues an ACTIVATE and then a READ. A request to a different row first closes the open row with a PRECHARGE, then activates the new row, then reads. The programmable precharge-to-activate and activate-to-read delays are filled with NOP cycles.

Byte masks on reads take effect two clocks after they are driven. At CAS latency 1 the block therefore places one NOP in front of every READ, and the mask for the first beat goes out in that NOP. At CAS latency 2 or 3 the READ goes out with no extra cycle. The four data beats are captured from the data bus and passed to the host one per cycle, each with a strobe, and the fourth beat also carries a completion pulse.

Refresh requests and bus-release requests are served between bursts. Either one closes every bank: the block issues a precharge of all banks when any row is open, and for a refresh it then issues the refresh command. Requests aimed at other address spaces pass by without touching the row state.

Top module: `sdr_rd_seq`

## Requirements
- R1: Commands appear on {cs_n,ras_n,cas_n,we_n} with these encodings: NOP 0111, ACTIVATE 0011, READ 0101, PRECHARGE 0010, REFRESH 0001. At CAS latency 2 or 3, a request to the open row of its bank puts READ on the bus in the first cycle after acceptance, with no ACTIVATE and no PRECHARGE.
- R2: At CAS latency 1, the cycle just before every READ is a NOP, and sd_dqm already carries the request's mask in that NOP. A row hit then reads in the second cycle after acceptance.
- R3: A request to a bank with no open row issues ACTIVATE with the row on sd_addr in the first cycle after acceptance. READ follows cfg_trcd cycles later, or cfg_trcd+1 cycles later at CAS latency 1.
- R4: A request to a different row in an active bank issues PRECHARGE to that bank, with sd_addr bit 10 low, in the first cycle after acceptance. ACTIVATE of the new row follows cfg_trp cycles later, and READ follows with the R3 spacing. The cycle after a single-bank PRECHARGE is always a NOP or an ACTIVATE.
- R5: If READ is issued in cycle t, sd_dqm equals the request mask (bit set = byte lane masked) in cycles t+CL-2 to t+CL+1. In every other cycle sd_dqm is all ones, including every cycle that carries ACTIVATE or PRECHARGE.
- R6: sd_dq is sampled in cycles t+CL to t+CL+3. In the cycle after each of those samples, rd_beat pulses and rd_data holds the sampled word. rd_done pulses together with the fourth rd_beat, in cycle t+CL+4.
- R7: A READ drives the bank on sd_ba, the column on the low bits of sd_addr, and sd_addr bit 10 low (no auto-precharge).
- R8: When a refresh request is served and some bank is open, a PRECHARGE with sd_addr bit 10 high comes in the first cycle, and REFRESH with ref_ack high comes cfg_trp cycles later. When no bank is open, REFRESH with ref_ack comes in the first cycle. Afterwards every bank counts as having no open row.
- R9: When a bus-release request is served and some bank is open, the block issues the all-bank PRECHARGE and raises rel_ack cfg_trp cycles later. When no bank is open, rel_ack comes in the first cycle. Afterwards every bank counts as having no open row.
- R10: A request with req_sdram low issues no command and leaves the row state unchanged.
- R11: Open-row state is kept separately per bank, so the same row in another bank is not a hit.
- R12: After reset the bus shows NOP, sd_dqm is all ones, req_ready is high, rd_beat, rd_done and both acks are low, and every bank has no open row.
- R13: req_ready is high only when the sequencer is idle and neither refresh nor release is requested. Refresh takes priority over release, and release over reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas | input | 2 | CAS latency, 1 to 3 |
| cfg_trp | input | 2 | Precharge-to-activate delay in clocks, 1 to 3 |
| cfg_trcd | input | 2 | Activate-to-read delay in clocks, 1 to 3 |
| req_valid | input | 1 | Read request present |
| req_sdram | input | 1 | Request targets the SDRAM space |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 9 | Starting column |
| req_mask | input | 2 | Byte-lane mask for the burst, 1 = masked |
| req_ready | output | 1 | Request accepted at this edge when valid |
| ref_req | input | 1 | Refresh request, held until ref_ack |
| ref_ack | output | 1 | Refresh command issued this cycle |
| rel_req | input | 1 | Bus-release request, held until rel_ack |
| rel_ack | output | 1 | Banks closed, bus may be released |
| cs_n | output | 1 | Chip select, low active |
| ras_n | output | 1 | Row strobe, low active |
| cas_n | output | 1 | Column strobe, low active |
| we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, column and precharge-all address |
| sd_dqm | output | 2 | Read byte mask |
| sd_dq | input | 16 | Read data from SDRAM |
| rd_data | output | 16 | Captured beat |
| rd_beat | output | 1 | rd_data holds a new beat |
| rd_done | output | 1 | Fourth beat of the burst |

## Verification
The bench builds the block with its default parameters: four banks, 13-bit rows, 9-bit columns and a 16-bit data bus. These parameters make the top row value 8191 and the bank-3 edge reachable. All timing comes through the configuration ports, so a single build sweeps CAS latency 1, 2 and 3 against every precharge and activate delay from 1 to 3. That sweep covers both the inserted byte-mask NOP and its absence, and every NOP padding length. Runs of hits, empties and misses spread across the banks, together with refresh and release arriving with banks open and with banks closed, reach all three paths out of idle.

// File: rtl/sdr_rd_pkg.sv
`timescale 1ns/1ps
package sdr_rd_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_ACT  = 4'b0011,
        CMD_READ = 4'b0101,
        CMD_PRE  = 4'b0010,
        CMD_REF  = 4'b0001
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        ROW_EMPTY = 2'd0,
        ROW_HIT   = 2'd1,
        ROW_MISS  = 2'd2
    } row_cls_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_WAIT, ST_ACT, ST_GAP,
        ST_READ, ST_BURST, ST_PALL, ST_REF, ST_REL
    } seq_st_e;

    localparam int BURST_LEN = 4;
    localparam int AP_BIT    = 10;

    function automatic sdr_cmd_e st_cmd(seq_st_e s);
        case (s)
            ST_PRE, ST_PALL: return CMD_PRE;
            ST_ACT:          return CMD_ACT;
            ST_READ:         return CMD_READ;
            ST_REF:          return CMD_REF;
            default:         return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdr_row_track.sv
`timescale 1ns/1ps
module sdr_row_track
    import sdr_rd_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    localparam int BA_W = $clog2(BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BA_W-1:0]  lk_bank,
    input  logic [ROW_W-1:0] lk_row,
    input  logic             set_en,
    input  logic [BA_W-1:0]  set_bank,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr_all,
    output row_cls_e         cls,
    output logic             any_open
);
    logic [ROW_W-1:0] rows [BANKS];
    logic [BANKS-1:0] vld;
    logic [BANKS-1:0] hit_vec;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            vld <= '0;
            for (int b = 0; b < BANKS; b++) rows[b] <= '0;
        end else if (set_en) begin
            vld[set_bank]  <= 1'b1;
            rows[set_bank] <= set_row;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_cmp
        assign hit_vec[b] = vld[b] && (rows[b] == lk_row);
    end

    always_comb begin
        if (!vld[lk_bank])      cls = ROW_EMPTY;
        else if (hit_vec[lk_bank]) cls = ROW_HIT;
        else                    cls = ROW_MISS;
    end

    assign any_open = |vld;
endmodule

// File: rtl/sdr_beat_cap.sv
`timescale 1ns/1ps
module sdr_beat_cap
    import sdr_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DQM_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic              gap,
    input  logic [1:0]        cas,
    input  logic [DQM_W-1:0]  mask,
    input  logic [DATA_W-1:0] dq,
    output logic [DQM_W-1:0]  dqm,
    output logic [DATA_W-1:0] data,
    output logic              beat,
    output logic              done,
    output logic              last
);
    localparam int IDX_W = $clog2(BURST_LEN);

    logic             active;
    logic [2:0]       cnt;
    logic [IDX_W-1:0] idx;
    logic             in_data;
    logic             dqm_on;
    logic [3:0]       cnt4, cas4;

    assign cnt4    = {1'b0, cnt};
    assign cas4    = {2'b00, cas};
    assign in_data = active && (cnt4 >= cas4);
    assign last    = in_data && (idx == IDX_W'(BURST_LEN - 1));

    always_comb begin
        dqm_on = gap
               || (rd_issue && (cas4 <= 4'd2))
               || (active && (cnt4 + 4'd2 >= cas4) && (cnt4 <= cas4 + 4'd1));
        dqm = dqm_on ? mask : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            data   <= '0;
            beat   <= 1'b0;
            done   <= 1'b0;
        end else begin
            beat <= 1'b0;
            done <= 1'b0;
            if (rd_issue) begin
                active <= 1'b1;
                cnt    <= 3'd1;
                idx    <= '0;
            end else if (active) begin
                cnt <= cnt + 3'd1;
                if (in_data) begin
                    data <= dq;
                    beat <= 1'b1;
                    idx  <= idx + 1'b1;
                    if (last) begin
                        done   <= 1'b1;
                        active <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sdr_rd_seq.sv
`timescale 1ns/1ps
module sdr_rd_seq
    import sdr_rd_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int DQM_W  = 2,
    localparam int BA_W  = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_cas,
    input  logic [1:0]        cfg_trp,
    input  logic [1:0]        cfg_trcd,
    input  logic              req_valid,
    input  logic              req_sdram,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQM_W-1:0]  req_mask,
    output logic              req_ready,
    input  logic              ref_req,
    output logic              ref_ack,
    input  logic              rel_req,
    output logic              rel_ack,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    input  logic [DATA_W-1:0] sd_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_beat,
    output logic              rd_done
);
    seq_st_e          state, wnext;
    logic [1:0]       wcnt;
    logic             pend_ref;
    logic [BA_W-1:0]  q_bank;
    logic [ROW_W-1:0] q_row;
    logic [COL_W-1:0] q_col;
    logic [DQM_W-1:0] q_mask;
    row_cls_e         cls;
    logic             any_open;
    logic             accept;
    logic             last_beat;
    sdr_cmd_e         cmd_now;
    seq_st_e          after_act;

    assign req_ready = (state == ST_IDLE) && !ref_req && !rel_req;
    assign accept    = req_ready && req_valid && req_sdram;
    assign after_act = (cfg_cas == 2'd1) ? ST_GAP : ST_READ;

    sdr_row_track #(.BANKS(BANKS), .ROW_W(ROW_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .lk_bank  (req_bank),
        .lk_row   (req_row),
        .set_en   (state == ST_ACT),
        .set_bank (q_bank),
        .set_row  (q_row),
        .clr_all  (state == ST_PALL || state == ST_REF || state == ST_REL),
        .cls      (cls),
        .any_open (any_open)
    );

    sdr_beat_cap #(.DATA_W(DATA_W), .DQM_W(DQM_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (state == ST_READ),
        .gap      (state == ST_GAP),
        .cas      (cfg_cas),
        .mask     (q_mask),
        .dq       (sd_dq),
        .dqm      (sd_dqm),
        .data     (rd_data),
        .beat     (rd_beat),
        .done     (rd_done),
        .last     (last_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wnext    <= ST_IDLE;
            wcnt     <= '0;
            pend_ref <= 1'b0;
            q_bank   <= '0;
            q_row    <= '0;
            q_col    <= '0;
            q_mask   <= '1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_req) begin
                        pend_ref <= 1'b1;
                        state    <= any_open ? ST_PALL : ST_REF;
                    end else if (rel_req) begin
                        pend_ref <= 1'b0;
                        state    <= any_open ? ST_PALL : ST_REL;
                    end else if (accept) begin
                        q_bank <= req_bank;
                        q_row  <= req_row;
                        q_col  <= req_col;
                        q_mask <= req_mask;
                        case (cls)
                            ROW_HIT:   state <= after_act;
                            ROW_EMPTY: state <= ST_ACT;
                            default:   state <= ST_PRE;
                        endcase
                    end
                end
                ST_PRE, ST_PALL: begin
                    if (cfg_trp <= 2'd1) begin
                        state <= (state == ST_PRE) ? ST_ACT : (pend_ref ? ST_REF : ST_REL);
                    end else begin
                        state <= ST_WAIT;
                        wcnt  <= cfg_trp - 2'd1;
                        wnext <= (state == ST_PRE) ? ST_ACT : (pend_ref ? ST_REF : ST_REL);
                    end
                end
                ST_ACT: begin
                    if (cfg_trcd <= 2'd1) begin
                        state <= after_act;
                    end else begin
                        state <= ST_WAIT;
                        wcnt  <= cfg_trcd - 2'd1;
                        wnext <= after_act;
                    end
                end
                ST_WAIT: begin
                    if (wcnt <= 2'd1) state <= wnext;
                    else              wcnt  <= wcnt - 2'd1;
                end
                ST_GAP:   state <= ST_READ;
                ST_READ:  state <= ST_BURST;
                ST_BURST: if (last_beat) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_now = st_cmd(state);
    assign {cs_n, ras_n, cas_n, we_n} = cmd_now;
    assign ref_ack = (state == ST_REF);
    assign rel_ack = (state == ST_REL);

    always_comb begin
        sd_addr = '0;
        sd_ba   = '0;
        case (state)
            ST_ACT: begin
                sd_addr = q_row;
                sd_ba   = q_bank;
            end
            ST_READ: begin
                sd_addr[COL_W-1:0] = q_col;
                sd_addr[AP_BIT]    = 1'b0;
                sd_ba              = q_bank;
            end
            ST_PRE:  sd_ba = q_bank;
            ST_PALL: sd_addr[AP_BIT] = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sdr_rd_seq_chk.sv
`timescale 1ns/1ps
module sdr_rd_seq_chk
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int DQM_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_cas,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic [DQM_W-1:0] sd_dqm,
    input logic             req_ready,
    input logic             ref_ack,
    input logic             rd_beat,
    input logic             rd_done
);
    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    // R5
    dqm_rowcmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT || cmd == CMD_PRE) |-> (sd_dqm == '1));

    // R4
    pre_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && !sd_addr[AP_BIT]) |=> (cmd == CMD_NOP || cmd == CMD_ACT));

    // R2
    cl1_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ && cfg_cas == 2'd1) |-> ($past(cmd) == CMD_NOP));

    // R6
    done_beat_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> rd_beat);

    // R8
    ref_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ref_ack |-> (cmd == CMD_REF));

    // R7
    read_ap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ) |-> !sd_addr[AP_BIT]);

    // R13
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cmd == CMD_NOP));
endmodule

bind sdr_rd_seq sdr_rd_seq_chk #(.ROW_W(ROW_W), .DQM_W(DQM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_cas   (cfg_cas),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .req_ready (req_ready),
    .ref_ack   (ref_ack),
    .rd_beat   (rd_beat),
    .rd_done   (rd_done)
);

// File: tb/sdr_rd_seq_tb.sv
`timescale 1ns/1ps
module sdr_rd_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_cas = 2'd2, cfg_trp = 2'd2, cfg_trcd = 2'd2;
    logic        req_valid = 1'b0, req_sdram = 1'b1;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [1:0]  req_mask = '0;
    logic        ref_req = 1'b0, rel_req = 1'b0;
    logic        req_ready, ref_ack, rel_ack;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq = '0;
    logic [15:0] rd_data;
    logic        rd_beat, rd_done;

    sdr_rd_seq u_dut (.*);

    always #10ns clk = ~clk;

    int total = 0, bad = 0;
    int cyc = 0, tid = 0;
    int n_act = 0, n_pre = 0, n_pall = 0, n_ref = 0, n_rd = 0;
    int t_act = -1, t_pre = -1, t_pall = -1, t_ref = -1, t_rd = -1000, t_done = -1;
    int act_row = 0, rd_col = 0, rd_ba = 0, rd_ap = 0, pall_ap = 0;
    int nb = 0;
    logic [15:0] beats [8];
    logic [1:0]  dqm_log [64];
    bit finished = 0;

    function automatic logic [15:0] pat(int id, int k);
        return 16'h5A00 ^ 16'(id << 4) ^ 16'(k);
    endfunction

    // SDRAM-side monitor and data model
    always @(negedge clk) begin
        logic [3:0] c;
        int k;
        cyc = cyc + 1;
        c = {cs_n, ras_n, cas_n, we_n};
        dqm_log[cyc & 63] = sd_dqm;
        if (c == 4'b0011) begin n_act++; t_act = cyc; act_row = int'(sd_addr); end
        if (c == 4'b0010 && !sd_addr[10]) begin n_pre++; t_pre = cyc; end
        if (c == 4'b0010 && sd_addr[10]) begin n_pall++; t_pall = cyc; pall_ap = 1; end
        if (c == 4'b0001) begin n_ref++; t_ref = cyc; end
        if (c == 4'b0101) begin
            n_rd++; t_rd = cyc; rd_col = int'(sd_addr[8:0]);
            rd_ba = int'(sd_ba); rd_ap = int'(sd_addr[10]);
        end
        if (rd_beat && nb < 8) begin beats[nb] = rd_data; nb++; end
        if (rd_done) t_done = cyc;
        k = cyc - t_rd - int'(cfg_cas);
        sd_dq = (k >= 0 && k <= 3) ? pat(tid, k) : 16'h0000;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic run_read(input int bank, row, col, mask, cl, trp, trcd, cls, ctx);
        int a0, p0, t_acc, exp_rd, exp_act, w;
        bit hit, miss;
        string tc;
        hit = (cls == 1); miss = (cls == 2);
        if (ctx == 8) tc = "R8";
        else if (ctx == 9) tc = "R9";
        else if (ctx == 10) tc = "R10";
        else if (ctx == 11) tc = "R11";
        else if (hit && cl == 1) tc = "R2";
        else if (hit) tc = "R1";
        else if (miss) tc = "R4";
        else tc = "R3";
        cfg_cas = 2'(cl); cfg_trp = 2'(trp); cfg_trcd = 2'(trcd);
        step();
        w = 0;
        while (!req_ready && w < 50) begin step(); w++; end
        tid++;
        a0 = n_act; p0 = n_pre; nb = 0;
        t_act = -1; t_pre = -1; t_done = -1;
        req_valid = 1'b1; req_sdram = 1'b1;
        req_bank = 2'(bank); req_row = 13'(row); req_col = 9'(col); req_mask = 2'(mask);
        t_acc = cyc;
        step();
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R13 ready low while busy", int'(req_ready), 0);
        w = 0;
        while (t_done < 0 && w < 40) begin step(); w++; end
        exp_rd = t_acc + 1 + (miss ? trp : 0) + (hit ? 0 : trcd) + (cl == 1 ? 1 : 0);
        chk(t_rd == exp_rd, {tc, " READ cycle"}, t_rd - t_acc, exp_rd - t_acc);
        chk(n_act - a0 == (hit ? 0 : 1), {tc, " ACTIVATE count"}, n_act - a0, hit ? 0 : 1);
        chk(n_pre - p0 == (miss ? 1 : 0), {tc, " PRECHARGE count"}, n_pre - p0, miss ? 1 : 0);
        if (miss) chk(t_pre == t_acc + 1, "R4 PRECHARGE cycle", t_pre - t_acc, 1);
        if (!hit) begin
            exp_act = t_acc + 1 + (miss ? trp : 0);
            chk(t_act == exp_act, {tc, " ACTIVATE cycle"}, t_act - t_acc, exp_act - t_acc);
            chk(act_row == row, {tc, " ACTIVATE row"}, act_row, row);
        end
        if (cl == 1)
            chk(dqm_log[(t_rd - 1) & 63] == 2'(mask), "R2 mask in NOP before READ",
                int'(dqm_log[(t_rd - 1) & 63]), mask);
        chk(rd_col == col && rd_ba == bank && rd_ap == 0, "R7 READ address",
            rd_col + 1000 * rd_ba + 100000 * rd_ap, col + 1000 * bank);
        for (int k = 0; k < 4; k++)
            chk(dqm_log[(t_rd + cl - 2 + k) & 63] == 2'(mask), "R5 mask window",
                int'(dqm_log[(t_rd + cl - 2 + k) & 63]), mask);
        chk(dqm_log[(t_rd + cl - 3) & 63] == 2'b11, "R5 mask before window",
            int'(dqm_log[(t_rd + cl - 3) & 63]), 3);
        chk(dqm_log[(t_rd + cl + 2) & 63] == 2'b11, "R5 mask after window",
            int'(dqm_log[(t_rd + cl + 2) & 63]), 3);
        chk(nb == 4, "R6 beat count", nb, 4);
        for (int k = 0; k < 4 && k < nb; k++)
            chk(beats[k] == pat(tid, k), "R6 beat data", int'(beats[k]), int'(pat(tid, k)));
        chk(t_done == t_rd + cl + 4, "R6 done cycle", t_done - t_rd, cl + 4);
    endtask

    // is_ref: 1 refresh, 0 release; open: banks expected open
    task automatic run_sys(input bit is_ref, input int trp, input bit open);
        int p0, r0, t0, t_ack, w;
        string tg;
        tg = is_ref ? "R8" : "R9";
        cfg_trp = 2'(trp);
        step();
        p0 = n_pall; r0 = n_ref; t_pall = -1; t_ref = -1; pall_ap = 0;
        t0 = cyc;
        if (is_ref) ref_req = 1'b1; else rel_req = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R13 ready low on system request", int'(req_ready), 0);
        w = 0; t_ack = -1;
        while (t_ack < 0 && w < 20) begin
            step(); w++;
            if ((is_ref && ref_ack) || (!is_ref && rel_ack)) t_ack = cyc;
        end
        ref_req = 1'b0; rel_req = 1'b0;
        chk(n_pall - p0 == (open ? 1 : 0), {tg, " precharge-all count"}, n_pall - p0, open ? 1 : 0);
        if (open) chk(t_pall == t0 + 1 && pall_ap == 1, {tg, " precharge-all cycle"}, t_pall - t0, 1);
        chk(t_ack == t0 + 1 + (open ? trp : 0), {tg, " ack cycle"}, t_ack - t0, 1 + (open ? trp : 0));
        if (is_ref) chk(n_ref - r0 == 1 && t_ref == t_ack, "R8 REFRESH issued", n_ref - r0, 1);
        else        chk(n_ref - r0 == 0, "R9 no REFRESH on release", n_ref - r0, 0);
    endtask

    typedef struct packed {
        int bank; int row; int col; int mask; int cl; int trp; int trcd; int cls; int ctx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{0,    5, 3, 0, 2, 2, 2, 0,  0},
        '{0,    5, 7, 1, 2, 2, 2, 1,  0},
        '{0,    9, 1, 2, 3, 3, 1, 2,  0},
        '{1,    9, 2, 0, 1, 1, 3, 0, 11},
        '{1,    9, 4, 3, 1, 1, 3, 1,  0},
        '{0,    9, 0, 1, 1, 1, 1, 1,  0},
        '{2,    0, 5, 2, 3, 1, 2, 0,  0},
        '{2, 8191, 6, 1, 1, 3, 3, 2,  0},
        '{3,    0, 8, 0, 2, 1, 1, 0,  0},
        '{3,    1, 9, 2, 1, 2, 1, 2,  0}
    };

    initial begin : watchdog
        #2ms;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int a0, c0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step();
        // R12 reset state
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R12 NOP after reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
        chk(sd_dqm == 2'b11, "R12 mask all ones", int'(sd_dqm), 3);
        chk(req_ready == 1'b1, "R12 ready", int'(req_ready), 1);
        chk(!rd_beat && !rd_done && !ref_ack && !rel_ack, "R12 strobes low",
            int'({rd_beat, rd_done, ref_ack, rel_ack}), 0);

        for (int i = 0; i < NV; i++)
            run_read(VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].mask, VECS[i].cl,
                     VECS[i].trp, VECS[i].trcd, VECS[i].cls, VECS[i].ctx);

        // R10: other address space leaves commands and row state alone
        step();
        c0 = n_act + n_pre + n_pall + n_rd + n_ref;
        req_valid = 1'b1; req_sdram = 1'b0; req_bank = 2'd3; req_row = 13'd77;
        repeat (4) step();
        req_valid = 1'b0; req_sdram = 1'b1;
        repeat (2) step();
        chk(n_act + n_pre + n_pall + n_rd + n_ref == c0, "R10 no command for other space",
            n_act + n_pre + n_pall + n_rd + n_ref - c0, 0);
        run_read(3, 1, 2, 0, 2, 2, 2, 1, 10);

        // R8: refresh with banks open, then bank is empty
        run_sys(1'b1, 3, 1'b1);
        run_read(0, 9, 4, 1, 2, 1, 2, 0, 8);
        // R8: refresh with no open bank right after another refresh
        run_sys(1'b1, 2, 1'b1);
        run_sys(1'b1, 2, 1'b0);
        // R9: release with banks open, then empty
        run_read(1, 4, 1, 0, 3, 1, 1, 0, 0);
        run_sys(1'b0, 2, 1'b1);
        run_read(1, 4, 3, 2, 3, 1, 1, 0, 9);
        run_sys(1'b0, 1, 1'b1);
        run_sys(1'b0, 1, 1'b0);

        // R13: refresh wins over a pending read and over release
        run_read(2, 6, 0, 0, 2, 1, 1, 0, 0);
        step();
        a0 = n_act + n_rd;
        c0 = n_ref;
        ref_req = 1'b1; rel_req = 1'b1; req_valid = 1'b1; req_row = 13'd6; req_bank = 2'd2;
        #1;
        chk(req_ready == 1'b0, "R13 ready low with requests pending", int'(req_ready), 0);
        for (int w = 0; w < 10 && !ref_ack; w++) step();
        chk(rel_ack == 1'b0 && ref_ack == 1'b1, "R13 refresh served first",
            int'({ref_ack, rel_ack}), 2);
        ref_req = 1'b0;
        for (int w = 0; w < 10 && !rel_ack; w++) step();
        chk(rel_ack == 1'b1, "R13 release after refresh", int'(rel_ack), 1);
        rel_req = 1'b0;
        req_valid = 1'b0;
        chk(n_ref - c0 == 1, "R13 single refresh", n_ref - c0, 1);
        repeat (12) step();
        // read pending during both requests must reach the bus only via a fresh request
        chk(n_act + n_rd - a0 <= 2, "R13 read not issued ahead", n_act + n_rd - a0, 2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule